// File: doc/BRIEF.md
# Two-Wire Debug Link Master

This block is the master end of a two-wire synchronous debug link to a small microcontroller. It drives a link clock, a single data line that carries traffic in both directions, and an active-low target reset. A host hands it one operation at a time over a valid/ready command port. The operation is one of four: shift a byte out, shift a byte in, run the debug-entry sequence, or run the debug-exit sequence. A single-cycle done pulse returns the result. Framing of multi-byte debug commands is left to the host.

The data line is half-duplex. Its output enable is asserted for a write byte and released for a read byte, and it is also released whenever the link is idle. Each byte takes eight link clock periods and is sent most-significant bit first. Outgoing bits change when the link clock falls, and incoming bits are sampled when it falls. Each clock phase lasts a programmable number of system cycles, so the link can run well below the target's ceiling of about 30 MHz. The phase length is captured when an operation is accepted.

The command port applies back-pressure by holding `cmd_ready` low for the whole of an operation, and a command offered during that time is not taken. The response port has no ready: `rsp_valid` is a one-cycle pulse, and the host must take `rsp_data` in that cycle.

Top module: `dbg_link_master`

## Requirements
- R1: After reset, `link_clk` is 0, `link_rst_n` is 1, `link_oe` is 0, `busy` is 0, `cmd_ready` is 1 and `rsp_valid` is 0.
- R2: A command is taken in a cycle where `cmd_valid` and `cmd_ready` are both 1. `cmd_ready` stays 0 from the cycle after acceptance until the done pulse, and `cmd_valid` is ignored during that time. `rsp_valid` is high for exactly one cycle per operation.
- R3: `cmd_op` encodes 2'b00 as write byte, 2'b01 as read byte, 2'b10 as debug entry and 2'b11 as debug exit.
- R4: A write byte holds `link_oe` at 1 for eight link clock periods. Each period is low then high, and bit 7 of `cmd_data` goes first. `link_dout` changes only on a falling `link_clk` while the line is driven.
- R5: A read byte holds `link_oe` at 0 for the whole transfer. It samples `link_din` at each of the eight falling `link_clk` edges, first sample into bit 7, and returns the byte in `rsp_data`.
- R6: A write byte returns in `rsp_data` the eight values sampled from the pad, which equals the byte driven when the pad follows `link_dout`.
- R7: Each link clock phase lasts H system cycles, where H is `half_period`, or 1 when `half_period` is 0. H is captured at acceptance, and later changes do not affect the running operation.
- R8: Debug entry holds `link_rst_n` at 0 for five phases. During those phases `link_clk` reads low, high, low, high, low, giving exactly two positive pulses. `link_rst_n` then returns to 1 with `link_clk` low.
- R9: Debug exit holds `link_rst_n` at 0 for two phases with `link_clk` held low, then returns it to 1.
- R10: `busy` is 1 from the cycle after acceptance until the done pulse. The done pulse falls in the cycle where `busy` returns to 0, which is 16H cycles after acceptance for a byte, 5H for entry and 2H for exit.
- R11: While idle, `link_clk` is 0 and `link_oe` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| half_period | input | DIV_W | System cycles per link clock phase (0 acts as 1) |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Command accepted when high with cmd_valid |
| cmd_op | input | 2 | Operation code (R3) |
| cmd_data | input | DATA_W | Byte to send on a write |
| rsp_valid | output | 1 | One-cycle done pulse |
| rsp_data | output | DATA_W | Byte sampled from the line |
| busy | output | 1 | Operation in progress |
| link_clk | output | 1 | Link clock to target |
| link_rst_n | output | 1 | Active-low target reset |
| link_dout | output | 1 | Data line drive value |
| link_oe | output | 1 | Data line output enable |
| link_din | input | 1 | Data line pad value |

## Verification
The bench attacks the turnaround in both directions. A read that left the enable on would fight the target, and a write that dropped it would send nothing. Both show up on the per-cycle comparison of `link_oe`. Sampling on the rising instead of the falling edge, or reversing the bit order, corrupts the returned byte. Phase lengths of 1, 2 and 3, together with a zero `half_period` and a divider change in mid-transfer, expose any divider that is off by one or not captured at acceptance. The entry and exit sequences are compared cycle by cycle, so a third clock pulse, a pulse during exit or an early reset release is reported. A command held valid during a busy operation must leave the pins untouched.

// File: rtl/dbgl_pkg.sv
package dbgl_pkg;
  // R3: operation codes on cmd_op
  typedef enum logic [1:0] {
    OP_WRITE = 2'b00,
    OP_READ  = 2'b01,
    OP_ENTER = 2'b10,
    OP_EXIT  = 2'b11
  } op_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_XFER,
    ST_ENTER,
    ST_EXIT
  } state_e;

  localparam int ENTER_PHASES = 5;
  localparam int EXIT_PHASES  = 2;
endpackage

// File: rtl/dbgl_phase_timer.sv
module dbgl_phase_timer #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             run,
  input  logic [DIV_W-1:0] period,
  output logic             tick
);
  logic [DIV_W-1:0] per_q;
  logic [DIV_W-1:0] cnt_q;
  logic [DIV_W-1:0] per_eff;

  // zero would stall the link; treat it as one cycle per phase
  assign per_eff = (period == '0) ? DIV_W'(1) : period;
  assign tick    = run && (cnt_q == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      per_q <= DIV_W'(1);
      cnt_q <= '0;
    end else if (start) begin
      per_q <= per_eff;
      cnt_q <= per_eff - DIV_W'(1);
    end else if (run) begin
      if (cnt_q == '0) cnt_q <= per_q - DIV_W'(1);
      else             cnt_q <= cnt_q - DIV_W'(1);
    end
  end
endmodule

// File: rtl/dbgl_shifter.sv
module dbgl_shifter #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [DATA_W-1:0] load_val,
  input  logic              shift,
  input  logic              sin,
  output logic              msb,
  output logic              last,
  output logic [DATA_W-1:0] next_val
);
  localparam int CNT_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;

  logic [DATA_W-1:0] sh_q;
  logic [CNT_W-1:0]  bit_q;

  assign msb      = sh_q[DATA_W-1];
  assign last     = (bit_q == CNT_W'(DATA_W-1));
  assign next_val = {sh_q[DATA_W-2:0], sin};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q  <= '0;
      bit_q <= '0;
    end else if (load) begin
      sh_q  <= load_val;
      bit_q <= '0;
    end else if (shift) begin
      sh_q  <= next_val;
      bit_q <= bit_q + CNT_W'(1);
    end
  end
endmodule

// File: rtl/dbg_link_master.sv
module dbg_link_master
  import dbgl_pkg::*;
#(
  parameter int DIV_W  = 8,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DIV_W-1:0]  half_period,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic [1:0]        cmd_op,
  input  logic [DATA_W-1:0] cmd_data,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_data,
  output logic              busy,
  output logic              link_clk,
  output logic              link_rst_n,
  output logic              link_dout,
  output logic              link_oe,
  input  logic              link_din
);
  localparam int PH_W = 3;

  state_e            state_q;
  logic              clk_q, rstn_q, oe_q, rv_q;
  logic [DATA_W-1:0] rd_q;
  logic [PH_W-1:0]   ph_q;
  logic              accept, tick, shift, last, msb;
  logic [DATA_W-1:0] next_val;
  op_e               op;

  assign op        = op_e'(cmd_op);
  assign cmd_ready = (state_q == ST_IDLE);
  assign busy      = (state_q != ST_IDLE);
  assign accept    = cmd_valid && cmd_ready;
  assign shift     = (state_q == ST_XFER) && tick && clk_q;

  dbgl_phase_timer #(.DIV_W(DIV_W)) u_timer (
    .clk    (clk),
    .rst_n  (rst_n),
    .start  (accept),
    .run    (busy),
    .period (half_period),
    .tick   (tick)
  );

  dbgl_shifter #(.DATA_W(DATA_W)) u_shift (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (accept && (op == OP_WRITE || op == OP_READ)),
    .load_val (cmd_data),
    .shift    (shift),
    .sin      (link_din),
    .msb      (msb),
    .last     (last),
    .next_val (next_val)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      clk_q   <= 1'b0;
      rstn_q  <= 1'b1;
      oe_q    <= 1'b0;
      rv_q    <= 1'b0;
      rd_q    <= '0;
      ph_q    <= '0;
    end else begin
      rv_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (accept) begin
            clk_q <= 1'b0;
            ph_q  <= '0;
            unique case (op)
              OP_WRITE: begin state_q <= ST_XFER;  oe_q   <= 1'b1; end
              OP_READ:  begin state_q <= ST_XFER;  oe_q   <= 1'b0; end
              OP_ENTER: begin state_q <= ST_ENTER; rstn_q <= 1'b0; end
              OP_EXIT:  begin state_q <= ST_EXIT;  rstn_q <= 1'b0; end
            endcase
          end
        end
        ST_XFER: begin
          if (tick) begin
            clk_q <= ~clk_q;
            if (clk_q && last) begin
              state_q <= ST_IDLE;
              oe_q    <= 1'b0;
              rv_q    <= 1'b1;
              rd_q    <= next_val;
            end
          end
        end
        ST_ENTER: begin
          if (tick) begin
            if (ph_q == PH_W'(ENTER_PHASES - 1)) begin
              state_q <= ST_IDLE;
              rstn_q  <= 1'b1;
              rv_q    <= 1'b1;
              rd_q    <= '0;
            end else begin
              ph_q  <= ph_q + PH_W'(1);
              clk_q <= ~clk_q;
            end
          end
        end
        ST_EXIT: begin
          if (tick) begin
            if (ph_q == PH_W'(EXIT_PHASES - 1)) begin
              state_q <= ST_IDLE;
              rstn_q  <= 1'b1;
              rv_q    <= 1'b1;
              rd_q    <= '0;
            end else begin
              ph_q <= ph_q + PH_W'(1);
            end
          end
        end
      endcase
    end
  end

  assign link_clk   = clk_q;
  assign link_rst_n = rstn_q;
  assign link_oe    = oe_q;
  assign link_dout  = msb;
  assign rsp_valid  = rv_q;
  assign rsp_data   = rd_q;
endmodule

// File: rtl/dbgl_link_checker.sv
module dbgl_link_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       cmd_valid,
  input logic       cmd_ready,
  input logic [1:0] cmd_op,
  input logic       rsp_valid,
  input logic       busy,
  input logic       link_clk,
  input logic       link_rst_n,
  input logic       link_dout,
  input logic       link_oe
);
  assert_idle_released_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!link_clk && !link_oe));

  assert_write_drives_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_ready && cmd_op == 2'b00) |=> (link_oe && busy));

  assert_read_releases_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_ready && cmd_op == 2'b01) |=> (!link_oe && busy));

  assert_dout_on_fall_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(link_oe) && link_oe && !$stable(link_dout)) |-> $fell(link_clk));

  assert_done_ends_busy_R10: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> ($past(busy) && !busy));

  assert_done_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);

  assert_reset_release_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(link_rst_n) |-> (!link_clk && rsp_valid));
endmodule

bind dbg_link_master dbgl_link_checker u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .cmd_valid  (cmd_valid),
  .cmd_ready  (cmd_ready),
  .cmd_op     (cmd_op),
  .rsp_valid  (rsp_valid),
  .busy       (busy),
  .link_clk   (link_clk),
  .link_rst_n (link_rst_n),
  .link_dout  (link_dout),
  .link_oe    (link_oe)
);

// File: tb/dbg_link_master_tb.sv
module dbg_link_master_tb;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] half_period = 8'd1;
  logic       cmd_valid = 1'b0;
  logic [1:0] cmd_op = 2'b00;
  logic [7:0] cmd_data = 8'h00;
  logic       cmd_ready, rsp_valid, busy;
  logic [7:0] rsp_data;
  logic       link_clk, link_rst_n, link_dout, link_oe, link_din;

  int         n_checks = 0;
  int         n_fail = 0;
  int         fall_idx = 0;
  logic [7:0] reply_q = 8'h00;
  bit         finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dbg_link_master u_dut (
    .clk(clk), .rst_n(rst_n), .half_period(half_period),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_op(cmd_op),
    .cmd_data(cmd_data), .rsp_valid(rsp_valid), .rsp_data(rsp_data),
    .busy(busy), .link_clk(link_clk), .link_rst_n(link_rst_n),
    .link_dout(link_dout), .link_oe(link_oe), .link_din(link_din)
  );

  // target pad model: the pad follows the master while driven,
  // otherwise the target presents its reply MSB first, one bit per fall
  always_comb begin
    if (link_oe)            link_din = link_dout;
    else if (fall_idx < 8)  link_din = reply_q[7 - fall_idx];
    else                    link_din = 1'b0;
  end
  always @(negedge link_clk) fall_idx = fall_idx + 1;

  task automatic check(input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h at %0t", tag, what, act, exp, $time);
    end
  endtask

  // expected pin state per cycle: {clk, rst_n, oe, dout, busy, rsp_valid}
  task automatic run_op(input logic [1:0] op, input logic [7:0] data,
                        input logic [7:0] reply, input int hp, input int hp_after,
                        input bit nudge, input string tag);
    logic [5:0] expq[$];
    logic [7:0] exp_rsp;
    int h = (hp == 0) ? 1 : hp;
    expq.delete();
    case (op)
      2'b00, 2'b01: begin // R3: write / read byte
        for (int b = 0; b < 8; b++)
          for (int lvl = 0; lvl < 2; lvl++)
            for (int c = 0; c < h; c++)
              expq.push_back({lvl[0], 1'b1, (op == 2'b00), data[7-b], 1'b1, 1'b0});
        exp_rsp = (op == 2'b00) ? data : reply;
      end
      2'b10: begin // R3: debug entry, clock low/high/low/high/low
        for (int p = 0; p < 5; p++)
          for (int c = 0; c < h; c++)
            expq.push_back({p[0], 1'b0, 1'b0, 1'b0, 1'b1, 1'b0});
        exp_rsp = 8'h00;
      end
      default: begin // R3: debug exit
        for (int c = 0; c < 2*h; c++)
          expq.push_back({1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0});
        exp_rsp = 8'h00;
      end
    endcase
    expq.push_back({1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1});

    @(negedge clk);
    half_period = 8'(hp);
    cmd_op = op; cmd_data = data; cmd_valid = 1'b1;
    reply_q = reply; fall_idx = 0;
    check("R2", "ready before accept", 32'(cmd_ready), 32'd1);
    @(posedge clk);
    @(negedge clk);
    half_period = 8'(hp_after);
    if (nudge) begin cmd_op = ~op; cmd_data = ~data; end
    else cmd_valid = 1'b0;
    for (int i = 0; i < expq.size(); i++) begin
      logic [5:0] e = expq[i];
      if (i > 0) @(negedge clk);
      if (nudge && i == 2) cmd_valid = 1'b0;
      check(tag, "link_clk", 32'(link_clk), 32'(e[5]));
      check(tag, "link_rst_n", 32'(link_rst_n), 32'(e[4]));
      check(tag, "link_oe", 32'(link_oe), 32'(e[3]));
      if (e[3]) check(tag, "link_dout", 32'(link_dout), 32'(e[2]));
      check("R10", "busy", 32'(busy), 32'(e[1]));
      check("R2", "cmd_ready", 32'(cmd_ready), 32'(!e[1]));
      check(tag, "rsp_valid", 32'(rsp_valid), 32'(e[0]));
      if (e[0]) check((op == 2'b00) ? "R6" : tag, "rsp_data", 32'(rsp_data), 32'(exp_rsp));
    end
    @(negedge clk);
    check("R2", "rsp_valid single cycle", 32'(rsp_valid), 32'd0);
    check("R11", "idle link_clk", 32'(link_clk), 32'd0);
    check("R11", "idle link_oe", 32'(link_oe), 32'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1", "link_clk", 32'(link_clk), 32'd0);
    check("R1", "link_rst_n", 32'(link_rst_n), 32'd1);
    check("R1", "link_oe", 32'(link_oe), 32'd0);
    check("R1", "busy", 32'(busy), 32'd0);
    check("R1", "cmd_ready", 32'(cmd_ready), 32'd1);
    check("R1", "rsp_valid", 32'(rsp_valid), 32'd0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    run_op(2'b10, 8'h00, 8'h00, 2, 2, 0, "R8");
    run_op(2'b00, 8'hA5, 8'h00, 1, 1, 0, "R4");
    run_op(2'b01, 8'h00, 8'h3C, 1, 1, 0, "R5");
    run_op(2'b00, 8'h81, 8'hFF, 2, 2, 0, "R6");
    run_op(2'b01, 8'hFF, 8'h96, 3, 3, 0, "R5");
    run_op(2'b01, 8'h00, 8'h00, 1, 1, 0, "R5");
    run_op(2'b01, 8'h00, 8'hFF, 2, 2, 0, "R5");
    run_op(2'b00, 8'h5E, 8'h00, 0, 0, 0, "R7");
    run_op(2'b01, 8'h00, 8'hC3, 2, 5, 0, "R7");
    run_op(2'b00, 8'h6B, 8'h00, 3, 1, 1, "R2");
    run_op(2'b10, 8'h00, 8'h00, 1, 1, 0, "R8");
    run_op(2'b11, 8'h00, 8'h00, 3, 3, 0, "R9");
    run_op(2'b11, 8'h00, 8'h00, 1, 1, 1, "R9");

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end
endmodule